// File: doc/BRIEF.md
# DRAM Refresh and Start-up Sequencer

This block owns the row and column strobes of an asynchronous page-mode DRAM whenever refresh work is due. Coming out of reset it holds the strobes inactive for a power-up pause. It then runs a short series of CAS-before-RAS refresh cycles to prime the array, and only after that raises a ready flag. From then on it schedules refresh in one of two ways. In distributed mode it runs one refresh cycle per interval. In burst mode it runs every row back to back once per retention window.

An access sequencer shares the strobes through a request/grant pair. A refresh that falls due while an access holds the bus waits for the request to drop, and it is served before any new request is granted. A self-refresh request is bracketed by refresh work on both sides: a single cycle in distributed mode, or a full row burst in burst mode. While self refresh lasts, both strobes are held low. If RAS stayed low past the long-hold threshold, the precharge that follows uses the longer self-refresh value. All delays are given in nanoseconds and turned into clock counts, rounded up, from the clock period parameter.

Top module: `dram_rfsh_seq`

## Requirements
- R1: During and right after reset, ras_n and cas_n are 1, and mem_ready, acc_gnt and sr_active are 0.
- R2: No strobe goes low until PAUSE_NS worth of clock cycles has passed since reset was released.
- R3: After the pause, exactly PRIME_N refresh cycles complete before mem_ready rises. Once mem_ready is 1 it stays 1.
- R4: In each refresh cycle, cas_n falls at least CSR_NS (in cycles) before ras_n falls. ras_n stays low for at least RAS_NS. ras_n is never low while cas_n is high, and both strobes rise in the same cycle.
- R5: Between a rise of ras_n and its next fall there are at least RP_NS worth of cycles.
- R6: With burst_mode=0, refresh cycles start at most INT_NS plus the longest granted access plus 40 cycles apart.
- R7: With burst_mode=1, ROWS refresh cycles run back to back at least once per WIN_NS window.
- R8: Neither strobe is low while acc_gnt is 1. A held request is granted within 300 cycles, and a refresh that falls due during a grant waits until the request is released.
- R9: After sr_req rises, the block runs one refresh (burst_mode=0) or ROWS refreshes (burst_mode=1) before sr_active rises. It then holds both strobes low while sr_req stays 1.
- R10: After sr_active falls, the block runs one refresh (burst_mode=0) or ROWS refreshes (burst_mode=1) before it grants any access.
- R11: When ras_n was held low for RASS_NS or longer, the next precharge lasts at least RPS_NS. After a shorter hold it lasts only the normal precharge, which is shorter than RPS_NS.
- R12: acc_gnt rises only while mem_ready is 1, sr_active is 0, and acc_req was 1 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_mode | input | 1 | 1: burst refresh per window, 0: distributed refresh per interval |
| sr_req | input | 1 | Level request to enter and stay in self refresh |
| acc_req | input | 1 | Access sequencer asks for the strobes; held until its cycle and precharge end |
| acc_gnt | output | 1 | Strobes handed to the access sequencer |
| ras_n | output | 1 | Row strobe, active low, driven for refresh only |
| cas_n | output | 1 | Column strobe, active low, driven for refresh only |
| mem_ready | output | 1 | Start-up pause and priming are done |
| sr_active | output | 1 | Self-refresh hold in progress |

## Verification
The clash that matters most is a refresh tick arriving in the same cycle that an access request is pending or a grant is live. It also matters when a tick and a self-refresh request arrive together. The bench provokes this with random request lengths and gaps from a fixed seed, spread over many refresh intervals in both modes. It judges the outcome by two things: the strobes are never low under a grant, and the spacing between refresh starts stays inside the bound set by the interval plus the longest access. Self-refresh entry and exit are driven directly, with short and long holds, and the refresh counts and precharge lengths around them are checked.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        S_PAUSE,
        S_PRIME,
        S_IDLE,
        S_RUN,
        S_SR_PRE,
        S_SR,
        S_SR_POST
    } seq_st_t;

    typedef enum logic [1:0] {
        E_IDLE,
        E_SETUP,
        E_ACT,
        E_PRE
    } eng_st_t;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int unsigned ns2cyc(longint unsigned ns, longint unsigned ps);
        longint unsigned c;
        c = (ns * 64'd1000 + ps - 64'd1) / ps;
        if (c == 64'd0) c = 64'd1;
        return 32'(c);
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_cbr_engine.sv
module dram_cbr_engine
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned CSR  = 1,
    parameter int unsigned RAS  = 6,
    parameter int unsigned RP   = 4,
    parameter int unsigned RPS  = 11,
    parameter int unsigned RASS = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic hold,
    output logic ras_n,
    output logic cas_n,
    output logic idle,
    output logic done
);
    localparam int unsigned MAXT = umax(umax(CSR, RAS), umax(umax(RP, RPS), RASS));
    localparam int TW = $clog2(MAXT + 1);

    eng_st_t        st;
    logic [TW-1:0]  cnt;
    logic [TW-1:0]  lcnt;
    logic           long_hold;

    assign long_hold = (lcnt >= TW'(RASS));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= E_IDLE;
            cnt  <= '0;
            lcnt <= '0;
        end else begin
            case (st)
                E_IDLE: begin
                    if (start) begin
                        st  <= E_SETUP;
                        cnt <= TW'(CSR - 1);
                    end
                end
                E_SETUP: begin
                    if (cnt == '0) begin
                        st   <= E_ACT;
                        cnt  <= TW'(RAS - 1);
                        lcnt <= TW'(1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                E_ACT: begin
                    if (!long_hold) lcnt <= lcnt + 1'b1;
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (!hold) begin
                        st  <= E_PRE;
                        cnt <= long_hold ? TW'(RPS - 1) : TW'(RP - 1);
                    end
                end
                default: begin
                    if (cnt == '0) st <= E_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    assign idle  = (st == E_IDLE);
    assign done  = (st == E_PRE) && (cnt == '0);
    assign cas_n = !((st == E_SETUP) || (st == E_ACT));
    assign ras_n = (st != E_ACT);

endmodule

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned INT_CYC = 1560,
    parameter int unsigned WIN_CYC = 3200000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    input  logic burst,
    output logic tick
);
    localparam int TW = $clog2(umax(INT_CYC, WIN_CYC) + 1);

    logic [TW-1:0] cnt;
    logic [TW-1:0] lim;

    assign lim  = burst ? TW'(WIN_CYC - 1) : TW'(INT_CYC - 1);
    assign tick = en && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || clr)   cnt <= '0;
        else if (tick)    cnt <= '0;
        else if (en)      cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/dram_rfsh_count.sv
module dram_rfsh_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] target,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign hit = (cnt == target);

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned CLK_PS   = 10000,
    parameter int unsigned PAUSE_NS = 200000,
    parameter int unsigned INT_NS   = 15600,
    parameter int unsigned WIN_NS   = 32000000,
    parameter int unsigned CSR_NS   = 10,
    parameter int unsigned RAS_NS   = 60,
    parameter int unsigned RP_NS    = 40,
    parameter int unsigned RPS_NS   = 110,
    parameter int unsigned RASS_NS  = 100000,
    parameter int unsigned ROWS     = 2048,
    parameter int unsigned PRIME_N  = 8,
    parameter int          CNT_W    = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic burst_mode,
    input  logic sr_req,
    input  logic acc_req,
    output logic acc_gnt,
    output logic ras_n,
    output logic cas_n,
    output logic mem_ready,
    output logic sr_active
);
    localparam int unsigned PAUSE_CYC = ns2cyc(PAUSE_NS, CLK_PS);
    localparam int unsigned INT_CYC   = ns2cyc(INT_NS, CLK_PS);
    localparam int unsigned WIN_CYC   = ns2cyc(WIN_NS, CLK_PS);
    localparam int unsigned CSR_CYC   = ns2cyc(CSR_NS, CLK_PS);
    localparam int unsigned RAS_CYC   = ns2cyc(RAS_NS, CLK_PS);
    localparam int unsigned RP_CYC    = ns2cyc(RP_NS, CLK_PS);
    localparam int unsigned RPS_CYC   = ns2cyc(RPS_NS, CLK_PS);
    localparam int unsigned RASS_CYC  = ns2cyc(RASS_NS, CLK_PS);
    localparam int          PW        = $clog2(PAUSE_CYC + 1);

    seq_st_t           st;
    logic [PW-1:0]     pcnt;
    logic [CNT_W-1:0]  target;
    logic [CNT_W-1:0]  mode_target;
    logic              pending;
    logic              gnt;
    logic              rdy;

    logic eng_start, eng_hold, eng_idle, eng_done;
    logic cnt_clr, cnt_hit, seq_done;
    logic tick, tmr_en, tmr_clr, pend_clr;
    logic in_seq;

    assign mode_target = burst_mode ? CNT_W'(ROWS) : CNT_W'(1);
    assign in_seq      = (st == S_PRIME) || (st == S_RUN) || (st == S_SR_PRE) ||
                         (st == S_SR) || (st == S_SR_POST);
    assign eng_start   = in_seq && eng_idle && !cnt_hit;
    assign eng_hold    = (st == S_SR) && sr_req;
    assign seq_done    = eng_idle && cnt_hit;
    assign tmr_en      = rdy && ((st == S_IDLE) || (st == S_RUN));
    assign tmr_clr     = (st == S_SR);

    always_comb begin
        cnt_clr  = 1'b0;
        pend_clr = 1'b0;
        case (st)
            S_PAUSE:   cnt_clr = (pcnt == PW'(PAUSE_CYC - 1));
            S_IDLE: begin
                if (!gnt && (pending || sr_req)) begin
                    cnt_clr  = 1'b1;
                    pend_clr = 1'b1;
                end
            end
            S_SR_PRE:  cnt_clr = seq_done;
            S_SR:      cnt_clr = seq_done;
            default:   cnt_clr = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_PAUSE;
            pcnt   <= '0;
            target <= '0;
            gnt    <= 1'b0;
            rdy    <= 1'b0;
        end else begin
            case (st)
                S_PAUSE: begin
                    pcnt <= pcnt + 1'b1;
                    if (pcnt == PW'(PAUSE_CYC - 1)) begin
                        st     <= S_PRIME;
                        target <= CNT_W'(PRIME_N);
                    end
                end
                S_PRIME: begin
                    if (seq_done) begin
                        st  <= S_IDLE;
                        rdy <= 1'b1;
                    end
                end
                S_IDLE: begin
                    if (gnt) begin
                        if (!acc_req) gnt <= 1'b0;
                    end else if (pending) begin
                        st     <= S_RUN;
                        target <= mode_target;
                    end else if (sr_req) begin
                        st     <= S_SR_PRE;
                        target <= mode_target;
                    end else if (acc_req) begin
                        gnt <= 1'b1;
                    end
                end
                S_RUN: begin
                    if (seq_done) st <= S_IDLE;
                end
                S_SR_PRE: begin
                    if (seq_done) begin
                        st     <= S_SR;
                        target <= CNT_W'(1);
                    end
                end
                S_SR: begin
                    if (seq_done) begin
                        st     <= S_SR_POST;
                        target <= mode_target;
                    end
                end
                default: begin
                    if (seq_done) st <= S_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           pending <= 1'b0;
        else if (pend_clr) pending <= 1'b0;
        else if (tick)     pending <= 1'b1;
    end

    dram_cbr_engine #(
        .CSR(CSR_CYC), .RAS(RAS_CYC), .RP(RP_CYC), .RPS(RPS_CYC), .RASS(RASS_CYC)
    ) u_eng (
        .clk(clk), .rst(rst), .start(eng_start), .hold(eng_hold),
        .ras_n(ras_n), .cas_n(cas_n), .idle(eng_idle), .done(eng_done)
    );

    dram_rfsh_timer #(
        .INT_CYC(INT_CYC), .WIN_CYC(WIN_CYC)
    ) u_tmr (
        .clk(clk), .rst(rst), .en(tmr_en), .clr(tmr_clr),
        .burst(burst_mode), .tick(tick)
    );

    dram_rfsh_count #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(eng_done),
        .target(target), .hit(cnt_hit)
    );

    assign acc_gnt   = gnt;
    assign mem_ready = rdy;
    assign sr_active = (st == S_SR);

endmodule

// File: rtl/dram_rfsh_chk.sv
module dram_rfsh_chk #(
    parameter int unsigned RAS_CYC = 6,
    parameter int unsigned CSR_CYC = 1
) (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic acc_req,
    input logic acc_gnt,
    input logic mem_ready,
    input logic sr_active
);
    logic [15:0] ras_low;
    logic [15:0] cas_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_low <= '0;
            cas_low <= '0;
        end else begin
            ras_low <= ras_n ? '0 : ((ras_low == 16'hffff) ? ras_low : ras_low + 1'b1);
            cas_low <= cas_n ? '0 : ((cas_low == 16'hffff) ? cas_low : cas_low + 1'b1);
        end
    end

    p_gnt_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        acc_gnt |-> (ras_n && cas_n));

    p_ras_needs_cas_r4: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> !cas_n);

    p_ras_width_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (32'(ras_low) >= RAS_CYC));

    p_cas_setup_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (32'(cas_low) >= CSR_CYC));

    p_gnt_ready_r12: assert property (@(posedge clk) disable iff (rst)
        acc_gnt |-> (mem_ready && !sr_active));

    p_gnt_req_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(acc_gnt) |-> $past(acc_req));

    p_ready_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        mem_ready |=> mem_ready);

endmodule

bind dram_rfsh_seq dram_rfsh_chk #(
    .RAS_CYC(RAS_CYC), .CSR_CYC(CSR_CYC)
) u_chk (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .acc_req(acc_req),
    .acc_gnt(acc_gnt), .mem_ready(mem_ready), .sr_active(sr_active)
);

// File: tb/dram_rfsh_seq_bench.sv
module dram_rfsh_seq_bench;
    localparam int PAUSE_CYC = 200;
    localparam int INT_CYC   = 100;
    localparam int CSR_CYC   = 2;
    localparam int RAS_CYC   = 5;
    localparam int RP_CYC    = 3;
    localparam int RPS_CYC   = 20;
    localparam int RASS_CYC  = 50;
    localparam int ROWS      = 16;
    localparam int PRIME_N   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic burst_mode = 1'b0;
    logic sr_req = 1'b0;
    logic acc_req = 1'b0;
    logic acc_gnt, ras_n, cas_n, mem_ready, sr_active;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    dram_rfsh_seq #(
        .CLK_PS(10000), .PAUSE_NS(2000), .INT_NS(1000), .WIN_NS(20000),
        .CSR_NS(20), .RAS_NS(50), .RP_NS(30), .RPS_NS(200), .RASS_NS(500),
        .ROWS(16), .PRIME_N(8), .CNT_W(12)
    ) u_dram_rfsh_seq (
        .clk(clk), .rst(rst), .burst_mode(burst_mode), .sr_req(sr_req),
        .acc_req(acc_req), .acc_gnt(acc_gnt), .ras_n(ras_n), .cas_n(cas_n),
        .mem_ready(mem_ready), .sr_active(sr_active)
    );

    function automatic void chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endfunction

    // monitor, sampled away from the active edge
    int cyc = 0;
    int nras = 0;
    int cas_fall_c = 0, ras_fall_c = 0, ras_rise_c = 0;
    bit have_rise = 0, last_long = 0;
    int last_prech = 0;
    bit gap_en = 0, gap_have = 0;
    int gap_last = 0, gap_max = 0;
    bit pr_ras = 1, pr_cas = 1;
    int ngrant = 0;
    bit pr_gnt = 0;
    bit ready_seen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (pr_cas && !cas_n) begin
                cas_fall_c = cyc;
                if (nras == 0) chk(cyc >= PAUSE_CYC, "R2", "first strobe cycle", cyc, PAUSE_CYC);
            end
            if (pr_ras && !ras_n) begin
                nras++;
                chk(cyc - cas_fall_c >= CSR_CYC, "R4", "cas to ras setup", cyc - cas_fall_c, CSR_CYC);
                if (have_rise) begin
                    last_prech = cyc - ras_rise_c;
                    chk(last_prech >= (last_long ? RPS_CYC : RP_CYC), "R5",
                        "precharge", last_prech, last_long ? RPS_CYC : RP_CYC);
                end
                if (gap_en && gap_have && (cyc - gap_last > gap_max)) gap_max = cyc - gap_last;
                gap_last = cyc;
                gap_have = 1;
            end
            if (!pr_ras && ras_n) begin
                chk(cyc - ras_fall_c >= RAS_CYC, "R4", "ras low width", cyc - ras_fall_c, RAS_CYC);
                chk(cas_n == 1'b1, "R4", "cas rises with ras", int'(cas_n), 1);
                last_long = (cyc - ras_fall_c) >= RASS_CYC;
                ras_rise_c = cyc;
                have_rise = 1;
            end
            if (pr_ras && !ras_n) ras_fall_c = cyc;
            if (acc_gnt && (!ras_n || !cas_n)) chk(0, "R8", "strobe under grant", 0, 1);
            if (acc_gnt && !pr_gnt) begin
                ngrant++;
                chk(mem_ready && !sr_active, "R12", "grant while not ready or in SR", 0, 1);
            end
            if (mem_ready && !ready_seen) begin
                ready_seen = 1;
                chk(nras == PRIME_N, "R3", "priming refresh count", nras, PRIME_N);
                chk(cyc >= PAUSE_CYC, "R3", "ready cycle", cyc, PAUSE_CYC);
            end
            if (ready_seen) chk(mem_ready, "R3", "ready stays high", int'(mem_ready), 1);
            if (cyc > 150000) begin
                chk(0, "WDOG", "watchdog expired", cyc, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
            pr_ras = ras_n;
            pr_cas = cas_n;
            pr_gnt = acc_gnt;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic run_random(int ncyc, string req);
        int t0;
        t0 = cyc;
        while (cyc - t0 < ncyc) begin
            int w = 0;
            int len = 1 + int'($urandom % 20);
            int gap = int'($urandom % 11);
            acc_req = 1'b1;
            while (!acc_gnt && w < 300) begin step(1); w++; end
            chk(acc_gnt, req, "request granted in time", w, 300);
            step(len);
            acc_req = 1'b0;
            step(gap + 1);
        end
    endtask

    task automatic do_sr(bit burst, int hold, bit long_exp);
        int n0, n1, n2, w;
        acc_req = 1'b0;
        burst_mode = burst;
        step(5);
        n0 = nras;
        sr_req = 1'b1;
        w = 0;
        while (!sr_active && w < 3000) begin step(1); w++; end
        n1 = nras;
        chk(sr_active, "R9", "self refresh entered", int'(sr_active), 1);
        chk(n1 - n0 >= (burst ? ROWS : 1), "R9", "refreshes before entry", n1 - n0, burst ? ROWS : 1);
        acc_req = 1'b1;
        step(hold);
        chk(!ras_n && !cas_n, "R9", "strobes held in self refresh", int'(ras_n) + int'(cas_n), 0);
        chk(!acc_gnt, "R12", "no grant during self refresh", int'(acc_gnt), 0);
        acc_req = 1'b0;
        sr_req = 1'b0;
        w = 0;
        while (sr_active && w < 500) begin step(1); w++; end
        n2 = nras;
        w = 0;
        while (nras == n2 && w < 200) begin step(1); w++; end
        if (long_exp)
            chk(last_prech >= RPS_CYC, "R11", "long precharge", last_prech, RPS_CYC);
        else
            chk(last_prech < RPS_CYC, "R11", "short precharge", last_prech, RPS_CYC - 1);
        step(burst ? ROWS * 12 + 40 : 40);
        if (burst)
            chk(nras - n2 >= ROWS, "R10", "burst after exit", nras - n2, ROWS);
        else
            chk(nras - n2 == 1, "R10", "single refresh after exit", nras - n2, 1);
    endtask

    initial begin
        int n0, w;
        void'($urandom(32'd2024));
        step(4);
        chk(ras_n && cas_n, "R1", "strobes idle in reset", int'(ras_n) + int'(cas_n), 2);
        chk(!mem_ready && !acc_gnt && !sr_active, "R1", "flags low in reset",
            int'(mem_ready) + int'(acc_gnt) + int'(sr_active), 0);
        rst = 1'b0;
        acc_req = 1'b1;
        step(1);
        chk(ras_n && cas_n && !mem_ready, "R1", "state after reset", int'(mem_ready), 0);
        w = 0;
        while (!mem_ready && w < 2000) begin
            step(1); w++;
            if (acc_gnt) chk(0, "R12", "grant before ready", 1, 0);
        end
        chk(mem_ready, "R3", "ready reached", int'(mem_ready), 1);
        w = 0;
        while (!acc_gnt && w < 300) begin step(1); w++; end
        chk(acc_gnt, "R12", "first grant after ready", int'(acc_gnt), 1);
        acc_req = 1'b0;
        step(3);

        // distributed mode with random access traffic
        burst_mode = 1'b0;
        gap_en = 1; gap_have = 0; gap_max = 0;
        n0 = nras;
        run_random(3000, "R8");
        gap_en = 0;
        chk(gap_max <= INT_CYC + 20 + 40, "R6", "max refresh spacing", gap_max, INT_CYC + 60);
        chk(nras - n0 >= 3000 / INT_CYC - 2, "R6", "refresh count in 3000 cycles", nras - n0, 28);
        chk(ngrant > 10, "R8", "grants issued", ngrant, 11);

        // burst mode
        acc_req = 1'b0;
        step(30);
        burst_mode = 1'b1;
        n0 = nras;
        run_random(5000, "R8");
        chk(nras - n0 >= 2 * ROWS, "R7", "burst refreshes in 5000 cycles", nras - n0, 2 * ROWS);
        chk(nras - n0 <= 4 * ROWS, "R7", "burst refresh upper bound", nras - n0, 4 * ROWS);

        // self refresh bracketing
        do_sr(1'b0, 20, 1'b0);
        do_sr(1'b1, 100, 1'b1);
        do_sr(1'b0, 120, 1'b1);
        do_sr(1'b1, 15, 1'b0);

        // traffic again after self refresh
        burst_mode = 1'b0;
        run_random(500, "R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule